// File: doc/BRIEF.md
# Strobe-Selected Control Register Bank

This block is the receiving end of a narrow parallel configuration bus. It holds eight write-only control registers of five bits each and drives all forty bits onto parallel outputs. Front-end switches, amplifier enables and attenuators hang directly off these outputs. The bus carries a shared 3-bit register offset, a shared 5-bit data word and a group of four enable lines. Each enable line belongs to one bank, so up to four banks can sit on the same offset and data wires.

A bank stores the data word into the register that the offset selects when its own enable line goes high. The enable comes from another clock domain, so it first passes through a synchronizer chain. The write happens on the clock edge after the synchronized rising edge is detected. The bus master must set up the offset and data while all enables are low and keep them steady until the write has landed. Holding the enable high for longer does not repeat the write. Nothing can be read back.

Top module: `strobe_reg_bank`

## Requirements
- R1: While reset is high, and on the first clock edge with reset high, all forty control outputs go to 0.
- R2: A write to offset k (0 to 7) places the data word in control output bits [5k+4:5k]. All other registers keep their values, and at most one 5-bit register changes per clock cycle.
- R3: The bank reacts only to enable bit `en_bus[BANK_SEL]`. Activity on the other three enable bits leaves its outputs unchanged, so writes aimed at one bank never alter another bank's registers.
- R4: With the default two synchronizer stages, if the enable is first sampled high at clock edge E0, the register updates at edge E2. Its output still shows the old value after E1.
- R5: The offset and data are taken at the capture edge (E2). A change to the data between E0 and E2 is the value that gets stored.
- R6: An enable held high over many cycles produces exactly one write. Later changes to the offset or data while the enable stays high are not stored.
- R7: An enable that is high across only a single rising clock edge still produces one complete write.
- R8: All five data bits are stored independently: the values 5'h00, 5'h1F and mixed patterns read back exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| en_bus | input | 4 | Shared enable group, one bit per bank, asynchronous to clk |
| ofs | input | 3 | Register offset, stable while the enable rises |
| wdata | input | 5 | Data word, stable while the enable rises |
| ctrl_out | output | 40 | All eight registers concatenated, register k in bits [5k+4:5k] |

## Verification
Four properties hold on every cycle. Reset clears the outputs. No more than one register changes in a cycle. Any change to the outputs follows a rising edge of the bank's own enable at exactly the synchronizer latency. The outputs stay quiet while that enable has been low. Other properties need the bench's scenarios: which register an offset maps to, that the stored value is the one present at the capture edge, that a long or a single-cycle enable each give exactly one write, and that neighbouring banks stay untouched. These depend on the value chosen by the bus master, and the checker cannot foresee that value.

// File: rtl/strb_bank_pkg.sv
package strb_bank_pkg;

    localparam int DEF_BANKS   = 4;
    localparam int DEF_REGS    = 8;
    localparam int DEF_FIELD_W = 5;
    localparam int DEF_SYNC    = 2;

    // Width of an index able to address n items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Phase of the enable seen by the edge detector.
    typedef enum logic [1:0] {
        EN_IDLE = 2'b00,
        EN_RISE = 2'b01,
        EN_HELD = 2'b11,
        EN_FALL = 2'b10
    } en_phase_e;

    function automatic en_phase_e classify(input logic now_v, input logic last_v);
        return en_phase_e'({last_v, now_v});
    endfunction

endpackage

// File: rtl/strb_edge_sync.sv
module strb_edge_sync #(
    parameter int DEPTH = strb_bank_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic en_async,
    output logic fire
);
    import strb_bank_pkg::*;

    logic [DEPTH-1:0] stg;
    logic             last_q;
    en_phase_e        phase;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= en_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[DEPTH-2:0], en_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= stg[DEPTH-1];
    end

    always_comb begin
        phase = classify(stg[DEPTH-1], last_q);
        fire  = (phase == EN_RISE);
    end

endmodule

// File: rtl/ofs_onehot.sv
module ofs_onehot #(
    parameter int NUM_REGS = strb_bank_pkg::DEF_REGS,
    localparam int OFS_W   = strb_bank_pkg::idx_bits(NUM_REGS)
) (
    input  logic                fire,
    input  logic [OFS_W-1:0]    ofs,
    output logic [NUM_REGS-1:0] wsel
);
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
            assign wsel[i] = fire && (ofs == OFS_W'(i));
        end
    endgenerate
endmodule

// File: rtl/field_store.sv
module field_store #(
    parameter int NUM_REGS = strb_bank_pkg::DEF_REGS,
    parameter int FIELD_W  = strb_bank_pkg::DEF_FIELD_W,
    localparam int TOTAL_W = NUM_REGS * FIELD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] wsel,
    input  logic [FIELD_W-1:0]  wval,
    output logic [TOTAL_W-1:0]  q
);
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic [FIELD_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)          r <= '0;
                else if (wsel[i]) r <= wval;
            end
            assign q[i*FIELD_W +: FIELD_W] = r;
        end
    endgenerate
endmodule

// File: rtl/strobe_reg_bank.sv
module strobe_reg_bank #(
    parameter int NUM_BANKS  = strb_bank_pkg::DEF_BANKS,
    parameter int NUM_REGS   = strb_bank_pkg::DEF_REGS,
    parameter int FIELD_W    = strb_bank_pkg::DEF_FIELD_W,
    parameter int SYNC_DEPTH = strb_bank_pkg::DEF_SYNC,
    parameter int BANK_SEL   = 0,
    localparam int OFS_W     = strb_bank_pkg::idx_bits(NUM_REGS),
    localparam int TOTAL_W   = NUM_REGS * FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] en_bus,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [FIELD_W-1:0]   wdata,
    output logic [TOTAL_W-1:0]   ctrl_out
);
    typedef struct packed {
        logic               fire;
        logic [OFS_W-1:0]   ofs;
        logic [FIELD_W-1:0] val;
    } wreq_t;

    logic                my_en;
    logic                fire;
    wreq_t               req;
    logic [NUM_REGS-1:0] wsel;

    assign my_en = en_bus[BANK_SEL];

    strb_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .en_async (my_en),
        .fire     (fire)
    );

    always_comb begin
        req.fire = fire;
        req.ofs  = ofs;
        req.val  = wdata;
    end

    ofs_onehot #(.NUM_REGS(NUM_REGS)) u_dec (
        .fire (req.fire),
        .ofs  (req.ofs),
        .wsel (wsel)
    );

    field_store #(.NUM_REGS(NUM_REGS), .FIELD_W(FIELD_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .wsel (wsel),
        .wval (req.val),
        .q    (ctrl_out)
    );

endmodule

// File: rtl/strobe_reg_bank_chk.sv
module strobe_reg_bank_chk #(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_REGS   = 8,
    parameter int FIELD_W    = 5,
    parameter int SYNC_DEPTH = 2,
    parameter int BANK_SEL   = 0,
    localparam int TOTAL_W   = NUM_REGS * FIELD_W,
    localparam int HIST      = SYNC_DEPTH + 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_BANKS-1:0] en_bus,
    input logic [TOTAL_W-1:0]   ctrl_out
);
    logic [HIST-1:0]     hist;
    logic [7:0]          age;
    logic [TOTAL_W-1:0]  prev_q;
    logic [NUM_REGS-1:0] slot_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist   <= '0;
            age    <= '0;
            prev_q <= '0;
        end else begin
            hist   <= {hist[HIST-2:0], en_bus[BANK_SEL]};
            age    <= (age == 8'hFF) ? age : age + 8'd1;
            prev_q <= ctrl_out;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++)
            slot_chg[i] = (ctrl_out[i*FIELD_W +: FIELD_W] != prev_q[i*FIELD_W +: FIELD_W]);
    end

    p_clear_after_reset_r1: assert property (@(posedge clk)
        rst |=> (ctrl_out == '0));

    p_single_slot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_chg));

    p_quiet_own_enable_r3: assert property (@(posedge clk) disable iff (rst)
        ((age > 8'(HIST)) && (hist[SYNC_DEPTH:0] == '0)) |-> (ctrl_out == prev_q));

    p_write_latency_r4: assert property (@(posedge clk) disable iff (rst)
        ((age > 8'(HIST)) && (ctrl_out != prev_q)) |->
            (hist[SYNC_DEPTH] && !hist[SYNC_DEPTH+1]));

endmodule

bind strobe_reg_bank strobe_reg_bank_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .NUM_REGS   (NUM_REGS),
    .FIELD_W    (FIELD_W),
    .SYNC_DEPTH (SYNC_DEPTH),
    .BANK_SEL   (BANK_SEL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_bus   (en_bus),
    .ctrl_out (ctrl_out)
);

// File: tb/sim_strobe_reg_bank.sv
module sim_strobe_reg_bank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] en_bus = '0;
    logic [2:0] ofs = '0;
    logic [4:0] wdata = '0;
    logic [39:0] q [4];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [4:0] mdl [4][8];

    always #5 clk = ~clk;

    strobe_reg_bank #(.BANK_SEL(0)) u0 (.clk(clk), .rst(rst), .en_bus(en_bus), .ofs(ofs), .wdata(wdata), .ctrl_out(q[0]));
    strobe_reg_bank #(.BANK_SEL(1)) u1 (.clk(clk), .rst(rst), .en_bus(en_bus), .ofs(ofs), .wdata(wdata), .ctrl_out(q[1]));
    strobe_reg_bank #(.BANK_SEL(2)) u2 (.clk(clk), .rst(rst), .en_bus(en_bus), .ofs(ofs), .wdata(wdata), .ctrl_out(q[2]));
    strobe_reg_bank #(.BANK_SEL(3)) u3 (.clk(clk), .rst(rst), .en_bus(en_bus), .ofs(ofs), .wdata(wdata), .ctrl_out(q[3]));

    typedef struct packed {
        logic [1:0] bank;
        logic [2:0] ofs;
        logic [4:0] val;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{2'd0, 3'd0, 5'h01}, '{2'd0, 3'd1, 5'h1F}, '{2'd0, 3'd2, 5'h0A},
        '{2'd0, 3'd3, 5'h15}, '{2'd0, 3'd4, 5'h10}, '{2'd0, 3'd5, 5'h03},
        '{2'd0, 3'd6, 5'h1C}, '{2'd0, 3'd7, 5'h11}, '{2'd1, 3'd7, 5'h1F},
        '{2'd2, 3'd3, 5'h06}, '{2'd3, 3'd0, 5'h19}, '{2'd1, 3'd2, 5'h0F},
        '{2'd0, 3'd1, 5'h00}, '{2'd3, 3'd5, 5'h12}, '{2'd2, 3'd7, 5'h1E},
        '{2'd1, 3'd7, 5'h04}
    };

    function automatic logic [39:0] flat(input int b);
        logic [39:0] r;
        for (int k = 0; k < 8; k++) r[k*5 +: 5] = mdl[b][k];
        return r;
    endfunction

    task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int b = 0; b < 4; b++) check(req, q[b], flat(b));
    endtask

    task automatic clear_model();
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 8; k++) mdl[b][k] = '0;
    endtask

    // setup phase with enables low, then a two-cycle enable, then settle
    task automatic bus_write(input int b, input logic [2:0] o, input logic [4:0] v);
        @(negedge clk);
        ofs   = o;
        wdata = v;
        @(negedge clk);
        en_bus[b] = 1'b1;
        repeat (2) @(negedge clk);
        en_bus = '0;
        repeat (4) @(negedge clk);
        mdl[b][o] = v;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        clear_model();
        repeat (3) @(negedge clk);
        check_all("R1 reset state");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 after release");

        // R2 R3 R8: table walk, every bank compared after each write
        for (int i = 0; i < 16; i++) begin
            bus_write(int'(VECS[i].bank), VECS[i].ofs, VECS[i].val);
            check_all("R2/R3/R8 vector");
        end

        // R3: enables of other banks only, bank 0 must stay unchanged
        @(negedge clk); ofs = 3'd4; wdata = 5'h0E;
        @(negedge clk); en_bus = 4'b1110;
        repeat (2) @(negedge clk); en_bus = '0;
        repeat (4) @(negedge clk);
        mdl[1][4] = 5'h0E; mdl[2][4] = 5'h0E; mdl[3][4] = 5'h0E;
        check("R3 other enables ignored", q[0], flat(0));

        // R4 latency and R5 capture-edge sampling
        @(negedge clk); ofs = 3'd6; wdata = 5'h05;
        @(negedge clk); en_bus[2] = 1'b1;        // sampled at E0
        @(negedge clk);                          // after E0
        @(negedge clk);                          // after E1
        check("R4 no update after E1", q[2], flat(2));
        wdata = 5'h1B;                           // changed before E2
        @(negedge clk);                          // after E2
        mdl[2][6] = 5'h1B;
        check("R4/R5 update at E2 with capture-edge data", q[2], flat(2));
        en_bus = '0;
        repeat (4) @(negedge clk);

        // R6: long enable, later changes ignored
        @(negedge clk); ofs = 3'd2; wdata = 5'h07;
        @(negedge clk); en_bus[3] = 1'b1;
        repeat (6) @(negedge clk);
        mdl[3][2] = 5'h07;
        check("R6 first write landed", q[3], flat(3));
        ofs = 3'd5; wdata = 5'h18;
        repeat (10) @(negedge clk);
        check("R6 held enable no rewrite", q[3], flat(3));
        en_bus = '0;
        repeat (5) @(negedge clk);
        check("R6 after release", q[3], flat(3));

        // R7: single-cycle enable
        @(negedge clk); ofs = 3'd0; wdata = 5'h1D;
        @(negedge clk); en_bus[1] = 1'b1;
        @(negedge clk); en_bus = '0;
        repeat (5) @(negedge clk);
        mdl[1][0] = 5'h1D;
        check("R7 single-cycle enable", q[1], flat(1));
        check_all("R7 all banks");

        // R1: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        clear_model();
        check_all("R1 mid-run reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule